// File: doc/BRIEF.md
# Split Micro-TLB Pair with Selectable Flush Policy

This block holds two small, fully associative translation caches that sit in front of a set-associative main TLB. The instruction-side cache has four entries and the data-side cache has eight. Each side answers a lookup in the same cycle. On a miss it raises a miss flag so that the main TLB can supply the translation. The main TLB returns the translation on a shared fill port, and the block stores it in a victim slot that a per-side round-robin pointer chooses.

Coherence with the main TLB is controlled by commands from the MMU command path. A configuration input selects one of two policies:

- **Legacy policy:** every plain main-TLB write also empties both caches.
- **Split policy:** plain writes leave the caches intact, so their higher associativity hides conflict misses in the two-way main TLB. Software then issues an explicit invalidate when a mapping is removed. That invalidate takes effect only while the main TLB's index register is valid.

A debug port reads any entry through a linear index.

Top module: `utlb_pair`

## Requirements
- R1: After reset every entry on both sides is invalid: lookups miss and debug reads report not valid.
- R2: A lookup with `*_req` high hits in the same cycle when a valid entry on that side holds the VPN, and `*_ppn` then shows that entry's PPN. Otherwise `*_miss` is high. The hit and miss flags are never high together.
- R3: An accepted fill (`fill_side` 0 selects the instruction side, 1 the data side) writes the slot named by that side's round-robin pointer, which starts at 0 and advances by one with wrap after each accepted fill. A fifth instruction-side fill therefore overwrites slot 0.
- R4: With `cfg_split`=0, a command with `cmd_op`=4 (plain write) invalidates every entry on both sides.
- R5: With `cfg_split`=1, a plain write (`cmd_op`=4) leaves all entries valid.
- R6: A command with `cmd_op`=6 (no-invalidate write) never changes any entry, under either policy.
- R7: A command with `cmd_op`=5 (invalidate) empties both sides when `idx_err`=0, and has no effect when `idx_err`=1.
- R8: When a clearing command and a fill arrive in the same cycle, the clear wins: the fill is discarded and the round-robin pointer does not move.
- R9: `dbg_idx` 0x200+k (k in 0..3) reads instruction entry k, and 0x400+k (k in 0..7) reads data entry k. Any other index reads as not valid with zero VPN and PPN.
- R10: A fill to one side is never visible to lookups on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_split | input | 1 | 1 selects the split policy, 0 the legacy policy |
| cmd_valid | input | 1 | Main-TLB command strobe |
| cmd_op | input | 4 | Command code: 4 plain write, 5 invalidate, 6 no-invalidate write |
| idx_err | input | 1 | Lookup-error flag of the main TLB index register |
| fill_valid | input | 1 | Refill strobe from the main TLB |
| fill_side | input | 1 | 0 instruction side, 1 data side |
| fill_vpn | input | VPN_W | Refilled virtual page number |
| fill_ppn | input | PPN_W | Refilled physical page number |
| i_req | input | 1 | Instruction-side lookup request |
| i_vpn | input | VPN_W | Instruction-side lookup VPN |
| i_hit | output | 1 | Instruction-side hit |
| i_miss | output | 1 | Instruction-side miss, asks for a refill |
| i_ppn | output | PPN_W | Instruction-side translated page |
| d_req | input | 1 | Data-side lookup request |
| d_vpn | input | VPN_W | Data-side lookup VPN |
| d_hit | output | 1 | Data-side hit |
| d_miss | output | 1 | Data-side miss, asks for a refill |
| d_ppn | output | PPN_W | Data-side translated page |
| dbg_idx | input | IDX_W | Debug read index |
| dbg_valid | output | 1 | Debug entry valid |
| dbg_vpn | output | VPN_W | Debug entry VPN |
| dbg_ppn | output | PPN_W | Debug entry PPN |

## Verification
Two events can fall in the same cycle: a refill returning from the main TLB, and a clearing command (an invalidate with a valid index, or a plain write under the legacy policy). The bench raises `fill_valid` and an invalidate on the same clock edge. It then looks up the refilled VPN, and a miss is expected. Next it issues a further fill and reads its slot through the debug port; the fill must land in the slot the pointer held before the collision, which shows that the discarded fill did not advance the pointer.

// File: rtl/utlb_pair.sv
module utlb_pair #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int I_N    = 4,
  parameter int D_N    = 8,
  parameter int IDX_W  = 11,
  parameter int I_BASE = 'h200,
  parameter int D_BASE = 'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_split,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic             idx_err,
  input  logic             fill_valid,
  input  logic             fill_side,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             i_req,
  input  logic [VPN_W-1:0] i_vpn,
  output logic             i_hit,
  output logic             i_miss,
  output logic [PPN_W-1:0] i_ppn,
  input  logic             d_req,
  input  logic [VPN_W-1:0] d_vpn,
  output logic             d_hit,
  output logic             d_miss,
  output logic [PPN_W-1:0] d_ppn,
  input  logic [IDX_W-1:0] dbg_idx,
  output logic             dbg_valid,
  output logic [VPN_W-1:0] dbg_vpn,
  output logic [PPN_W-1:0] dbg_ppn
);
  localparam int IPW = (I_N > 1) ? $clog2(I_N) : 1;
  localparam int DPW = (D_N > 1) ? $clog2(D_N) : 1;
  localparam logic [3:0] OP_WR = 4'd4, OP_INV = 4'd5, OP_WRNI = 4'd6;

  logic [I_N-1:0]   i_vld;
  logic [D_N-1:0]   d_vld;
  logic [VPN_W-1:0] i_tag [I_N];
  logic [PPN_W-1:0] i_pa  [I_N];
  logic [VPN_W-1:0] d_tag [D_N];
  logic [PPN_W-1:0] d_pa  [D_N];
  logic [IPW-1:0]   i_ptr;
  logic [DPW-1:0]   d_ptr;
  logic             clr, i_fill, d_fill, i_match, d_match;

  assign clr = cmd_valid && ((cmd_op == OP_WR && !cfg_split) || (cmd_op == OP_INV && !idx_err));
  assign i_fill = fill_valid && !fill_side && !clr;
  assign d_fill = fill_valid &&  fill_side && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_vld <= '0;
      d_vld <= '0;
      i_ptr <= '0;
      d_ptr <= '0;
    end else if (clr) begin
      i_vld <= '0;
      d_vld <= '0;
    end else begin
      if (i_fill) begin
        i_vld[i_ptr] <= 1'b1;
        i_ptr <= (i_ptr == IPW'(I_N - 1)) ? '0 : i_ptr + 1'b1;
      end
      if (d_fill) begin
        d_vld[d_ptr] <= 1'b1;
        d_ptr <= (d_ptr == DPW'(D_N - 1)) ? '0 : d_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (i_fill) begin
      i_tag[i_ptr] <= fill_vpn;
      i_pa[i_ptr]  <= fill_ppn;
    end
    if (d_fill) begin
      d_tag[d_ptr] <= fill_vpn;
      d_pa[d_ptr]  <= fill_ppn;
    end
  end

  always_comb begin
    i_match = 1'b0;
    i_ppn   = '0;
    for (int k = 0; k < I_N; k++)
      if (i_vld[k] && i_tag[k] == i_vpn) begin
        i_match = 1'b1;
        i_ppn   = i_pa[k];
      end
    d_match = 1'b0;
    d_ppn   = '0;
    for (int k = 0; k < D_N; k++)
      if (d_vld[k] && d_tag[k] == d_vpn) begin
        d_match = 1'b1;
        d_ppn   = d_pa[k];
      end
  end

  assign i_hit  = i_req && i_match;
  assign i_miss = i_req && !i_match;
  assign d_hit  = d_req && d_match;
  assign d_miss = d_req && !d_match;

  always_comb begin
    dbg_valid = 1'b0;
    dbg_vpn   = '0;
    dbg_ppn   = '0;
    for (int k = 0; k < I_N; k++)
      if (dbg_idx == IDX_W'(I_BASE + k) && i_vld[k]) begin
        dbg_valid = 1'b1;
        dbg_vpn   = i_tag[k];
        dbg_ppn   = i_pa[k];
      end
    for (int k = 0; k < D_N; k++)
      if (dbg_idx == IDX_W'(D_BASE + k) && d_vld[k]) begin
        dbg_valid = 1'b1;
        dbg_vpn   = d_tag[k];
        dbg_ppn   = d_pa[k];
      end
  end

  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (i_vld == '0 && d_vld == '0));
  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(i_hit && i_miss) && !(d_hit && d_miss));
  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n) i_fill |=> i_vld[$past(i_ptr)]);
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (i_vld == '0 && d_vld == '0));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (i_ptr == $past(i_ptr) && d_ptr == $past(d_ptr)));
  p_ni_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRNI && !fill_valid) |=> (i_vld == $past(i_vld) && d_vld == $past(d_vld)));
endmodule

// File: tb/sim_utlb_pair.sv
module sim_utlb_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_split = 1'b0, cmd_valid = 1'b0, idx_err = 1'b0;
  logic [3:0] cmd_op = '0;
  logic fill_valid = 1'b0, fill_side = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic i_req = 1'b0, d_req = 1'b0;
  logic [19:0] i_vpn = '0, d_vpn = '0;
  logic i_hit, i_miss, d_hit, d_miss, dbg_valid;
  logic [19:0] i_ppn, d_ppn, dbg_vpn, dbg_ppn;
  logic [10:0] dbg_idx = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  utlb_pair u0 (.clk, .rst_n, .cfg_split, .cmd_valid, .cmd_op, .idx_err,
    .fill_valid, .fill_side, .fill_vpn, .fill_ppn,
    .i_req, .i_vpn, .i_hit, .i_miss, .i_ppn,
    .d_req, .d_vpn, .d_hit, .d_miss, .d_ppn,
    .dbg_idx, .dbg_valid, .dbg_vpn, .dbg_ppn);

  function automatic logic [19:0] pa(input logic [19:0] v);
    return v + 20'h10000;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic side, input logic [19:0] v);
    @(negedge clk);
    fill_valid = 1'b1; fill_side = side; fill_vpn = v; fill_ppn = pa(v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; idx_err = err;
    @(negedge clk);
    cmd_valid = 1'b0; idx_err = 1'b0;
  endtask

  task automatic look(input string req, input logic side, input logic [19:0] v,
                      input logic exp_hit, input logic [19:0] exp_pa);
    @(negedge clk);
    if (side) begin d_req = 1'b1; d_vpn = v; end
    else begin i_req = 1'b1; i_vpn = v; end
    #1;
    if (side) begin
      chk(req, {d_hit, d_miss}, {exp_hit, !exp_hit});
      if (exp_hit) chk(req, d_ppn, exp_pa);
    end else begin
      chk(req, {i_hit, i_miss}, {exp_hit, !exp_hit});
      if (exp_hit) chk(req, i_ppn, exp_pa);
    end
    i_req = 1'b0; d_req = 1'b0;
  endtask

  task automatic dbg(input string req, input logic [10:0] idx, input logic ev, input logic [19:0] evpn);
    @(negedge clk);
    dbg_idx = idx;
    #1;
    chk(req, {dbg_valid, dbg_vpn, dbg_ppn}, {ev, ev ? evpn : 20'h0, ev ? pa(evpn) : 20'h0});
  endtask

  localparam int NV = 7;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 20'h00100, 1'b0, 20'h0},
    {1'b0, 20'h00101, 1'b1, 20'h10101},
    {1'b0, 20'h00104, 1'b1, 20'h10104},
    {1'b1, 20'h00207, 1'b1, 20'h10207},
    {1'b1, 20'h00200, 1'b1, 20'h10200},
    {1'b1, 20'h00101, 1'b0, 20'h0},
    {1'b0, 20'h00200, 1'b0, 20'h0}
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look("R1", 1'b0, 20'h0, 1'b0, 20'h0);
    dbg("R1", 11'h200, 1'b0, 20'h0);
    dbg("R1", 11'h400, 1'b0, 20'h0);

    for (int k = 0; k < 5; k++) fill(1'b0, 20'h100 + 20'(k));
    for (int k = 0; k < 8; k++) fill(1'b1, 20'h200 + 20'(k));
    for (int n = 0; n < NV; n++)
      look(n < 3 ? "R2/R3" : "R2/R10", VEC[n][41], VEC[n][40:21], VEC[n][20], VEC[n][19:0]);

    dbg("R3/R9", 11'h200, 1'b1, 20'h104);
    dbg("R9", 11'h203, 1'b1, 20'h103);
    dbg("R9", 11'h404, 1'b1, 20'h204);
    dbg("R9", 11'h204, 1'b0, 20'h0);
    dbg("R9", 11'h300, 1'b0, 20'h0);

    cfg_split = 1'b1;
    cmd(4'd4, 1'b0);
    look("R5", 1'b0, 20'h101, 1'b1, pa(20'h101));
    cmd(4'd6, 1'b0);
    look("R6", 1'b0, 20'h101, 1'b1, pa(20'h101));
    cmd(4'd5, 1'b1);
    look("R7 ignored", 1'b0, 20'h101, 1'b1, pa(20'h101));
    look("R7 ignored", 1'b1, 20'h203, 1'b1, pa(20'h203));
    cmd(4'd5, 1'b0);
    look("R7", 1'b0, 20'h101, 1'b0, 20'h0);
    look("R7", 1'b1, 20'h203, 1'b0, 20'h0);

    fill(1'b0, 20'h300);
    dbg("R3 pointer kept", 11'h201, 1'b1, 20'h300);

    cfg_split = 1'b0;
    cmd(4'd4, 1'b0);
    look("R4", 1'b0, 20'h300, 1'b0, 20'h0);
    fill(1'b0, 20'h350);
    cmd(4'd6, 1'b0);
    look("R6", 1'b0, 20'h350, 1'b1, pa(20'h350));

    @(negedge clk);
    fill_valid = 1'b1; fill_side = 1'b0; fill_vpn = 20'h400; fill_ppn = pa(20'h400);
    cmd_valid = 1'b1; cmd_op = 4'd5; idx_err = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0; cmd_valid = 1'b0;
    look("R8", 1'b0, 20'h400, 1'b0, 20'h0);
    look("R8", 1'b0, 20'h350, 1'b0, 20'h0);
    fill(1'b0, 20'h500);
    dbg("R8", 11'h203, 1'b1, 20'h500);
    dbg("R8", 11'h202, 1'b0, 20'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule